// File: doc/BRIEF.md
# Banked Aligned Vector Load/Store Unit

This unit carries out vector loads and vector stores for a four-lane data-parallel datapath. Each request carries a single start address; the four element addresses are implied as that address and the three that follow it. The memory behind the unit is split into four independent banks, and element k of a vector always sits in bank k. All four elements therefore move in one access, with every bank addressed at the same row.

The start address must sit on a four-element boundary. A misaligned request does not touch any bank and is answered with a fault. Every accepted request gets exactly one response in the following cycle. A load response carries the four elements. A store response or a fault response carries zeros. Requests use a valid/ready handshake, and the unit takes no new request while a response is waiting to be consumed.

Top module: `vec_bank_lsu`

## Requirements
- R1: An accepted store whose start address has bits [1:0] equal to zero enables all four banks with write set, in the acceptance cycle. Bank k receives lane k of the store data at row address[AW-1:2].
- R2: An accepted aligned load enables all four banks without write, in the acceptance cycle, at row address[AW-1:2]. Banks return read data one cycle after enable and hold it until their next enable.
- R3: An accepted request whose start address has bits [1:0] nonzero enables no bank. Its response has fault set to 1 and data equal to zero.
- R4: Every accepted request produces exactly one response, with response valid high in the cycle after acceptance. An aligned store responds with fault 0 and data zero.
- R5: While response valid is high and response ready is low, the response stays valid and unchanged, and request ready is low.
- R6: After reset, response valid is low, request ready is high and no bank is enabled.
- R7: Lane k of store data, load data, bank write data and bank read data occupies bits [k*DW +: DW]. The row for bank k occupies bits [k*RW +: RW] of the bank row bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Element start address |
| req_wdata | input | 4*DW | Store data, four lanes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Misaligned start address |
| rsp_data | output | 4*DW | Load data, four lanes |
| bank_en | output | 4 | Per-bank access enable |
| bank_we | output | 4 | Per-bank write enable |
| bank_row | output | 4*RW | Per-bank row address |
| bank_wdata | output | 4*DW | Per-bank write data |
| bank_rdata | input | 4*DW | Per-bank read data |

## Verification
The checks use a shadow copy of the banks. A wrong lane mapping or row computation shows up at the next load of the affected row as swapped or stale elements. A dropped or stray bank enable on a misaligned request is seen at the bank ports in that same cycle, and later as corrupted data on read-back. A wrong response state is caught at the response port within one cycle. This covers a lost or duplicated response, a fault flag not cleared, or a response that changes while stalled.

// File: rtl/vec_bank_lsu.sv
module vec_bank_lsu #(
  parameter int DW    = 16,
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic [AW-1:0]         req_addr,
  input  logic [LANES*DW-1:0]   req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_fault,
  output logic [LANES*DW-1:0]   rsp_data,
  output logic [LANES-1:0]      bank_en,
  output logic [LANES-1:0]      bank_we,
  output logic [LANES*(AW-$clog2(LANES))-1:0] bank_row,
  output logic [LANES*DW-1:0]   bank_wdata,
  input  logic [LANES*DW-1:0]   bank_rdata
);
  localparam int OW = $clog2(LANES);
  localparam int RW = AW - OW;

  logic fire, misal, go, rsp_load;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign misal     = |req_addr[OW-1:0];
  assign go        = fire && !misal;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign bank_en[k]                = go;
    assign bank_we[k]                = go && req_store;
    assign bank_row[k*RW +: RW]      = req_addr[AW-1:OW];
    assign bank_wdata[k*DW +: DW]    = req_wdata[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_load  <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_fault <= misal;
      rsp_load  <= !req_store && !misal;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_data = (rsp_valid && rsp_load) ? bank_rdata : '0;

  // R1
  a_r1_store_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_store && req_addr[OW-1:0] == '0) |-> (&bank_en && &bank_we));
  // R3
  a_r3_no_bank_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OW-1:0] != '0) |-> (bank_en == '0));
  a_r3_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[OW-1:0] != '0) |=> (rsp_valid && rsp_fault && rsp_data == '0));
  // R4
  a_r4_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)));
  a_r5_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/tb_vec_bank_lsu.sv
module tb_vec_bank_lsu;
  localparam int DW = 16, AW = 10, LANES = 4, RW = AW - 2, ROWS = 1 << RW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0, bank_wdata, bank_rdata, rsp_data;
  logic req_ready, rsp_valid, rsp_fault;
  logic [LANES-1:0] bank_en, bank_we;
  logic [LANES*RW-1:0] bank_row;

  int total = 0, bad = 0;
  logic stall_mode = 0;
  logic [DW-1:0] mem [LANES][ROWS];
  logic [DW-1:0] shadow [LANES][ROWS];
  logic [DW-1:0] rd [LANES];
  logic [LANES*DW-1:0] exp_data_q [$];
  logic exp_fault_q [$];
  int exp_tag_q [$];

  always #4 clk = ~clk;

  vec_bank_lsu #(.DW(DW), .AW(AW), .LANES(LANES)) dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_store, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_fault, .rsp_data,
    .bank_en, .bank_we, .bank_row, .bank_wdata, .bank_rdata);

  // bank model: one-cycle read, holds read data until next enable (R2, R7 packing)
  for (genvar k = 0; k < LANES; k++) begin : g_bank
    assign bank_rdata[k*DW +: DW] = rd[k];
    always @(posedge clk) if (bank_en[k]) begin
      if (bank_we[k]) mem[k][bank_row[k*RW +: RW]] <= bank_wdata[k*DW +: DW];
      else rd[k] <= mem[k][bank_row[k*RW +: RW]];
    end
  end

  task automatic check(input bit ok, input int tag, input logic [LANES*DW-1:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit st, input logic [AW-1:0] a, input logic [LANES*DW-1:0] wd, input int tag);
    logic [LANES*DW-1:0] e;
    @(negedge clk);
    req_valid = 1; req_store = st; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    e = '0;
    if (a[1:0] == 2'b00) begin
      for (int k = 0; k < LANES; k++) begin
        if (st) shadow[k][a[AW-1:2]] = wd[k*DW +: DW];
        else e[k*DW +: DW] = shadow[k][a[AW-1:2]];
      end
    end
    exp_data_q.push_back(e);
    exp_fault_q.push_back(a[1:0] != 2'b00);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor; R5 hold and R3 bank-silence checks
  logic prev_stall = 0;
  logic [LANES*DW-1:0] prev_data;
  logic prev_fault;
  always @(negedge clk) if (rst_n) begin
    if (req_valid && req_ready && req_addr[1:0] != 2'b00)
      check(bank_en == '0, 3, {60'd0, bank_en}, '0);
    if (prev_stall)
      check(rsp_valid && rsp_data == prev_data && rsp_fault == prev_fault, 5, rsp_data, prev_data);
    if (rsp_valid && !rsp_ready) check(!req_ready, 5, {63'd0, req_ready}, '0);
    if (rsp_valid && rsp_ready) begin
      if (exp_data_q.size() == 0) check(0, 4, rsp_data, '0);
      else begin
        logic [LANES*DW-1:0] e; logic f; int t;
        e = exp_data_q.pop_front(); f = exp_fault_q.pop_front(); t = exp_tag_q.pop_front();
        check(rsp_data == e && rsp_fault == f, t, {rsp_fault, rsp_data[LANES*DW-2:0]}, {f, e[LANES*DW-2:0]});
      end
    end
    prev_stall = rsp_valid && !rsp_ready;
    prev_data = rsp_data; prev_fault = rsp_fault;
  end

  // response-ready driver, changes just after the rising edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      rsp_ready = stall_mode ? ((c * 7 + c / 3) % 3 != 0) : 1'b1;
    end
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) for (int r = 0; r < ROWS; r++) begin
      mem[k][r] = DW'((k << 12) ^ (r * 37));
      shadow[k][r] = mem[k][r];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R6
    check(!rsp_valid && req_ready && bank_en == '0, 6, {rsp_valid, req_ready, bank_en}, 6'b010000);
    send(1, 10'd20, 64'h1111_2222_3333_4444, 1);    // R1 store row 5
    send(0, 10'd20, '0, 7);                        // R7 lane packing on read-back
    send(0, 10'd36, '0, 2);                        // R2 untouched row 9
    send(1, 10'd21, 64'hdead_beef_dead_beef, 3);   // R3 misaligned store
    send(0, 10'd20, '0, 3);                        // R3 row 5 unchanged
    send(0, 10'd2, '0, 3);                         // R3 misaligned load
    send(1, 10'd0, 64'h0a0b_0c0d_0e0f_0102, 4);    // R4 store ack, row 0
    send(1, 10'd1020, 64'hffff_0000_aaaa_5555, 1); // R1 top row
    send(0, 10'd0, '0, 2);
    send(0, 10'd1020, '0, 2);
    idle(2);
    stall_mode = 1;                                // R5 back-pressure
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a = AW'((i * 173 + 11) % 1024);
      if (i % 5 == 0) a[1:0] = 2'b00;
      if (i % 3 == 1) a[1:0] = 2'b00;
      send(i % 4 == 0, a, {16'(i), 16'(i * 3), 16'(i * 5), 16'(i * 9)}, (i % 4 == 0) ? 1 : 2);
    end
    for (int r = 0; r < 8; r++) send(0, AW'(r * 4), '0, 2);
    idle(10);
    stall_mode = 0;
    idle(5);
    check(exp_data_q.size() == 0, 4, 64'(exp_data_q.size()), '0); // R4 no lost response
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule